// File: doc/BRIEF.md
# Byte-Stream Quadlet Packer for an AV Ingest Port

This block takes the byte-wide transmit-side stream of an audio/video application port and turns it into 32-bit quadlets for a downstream quadlet FIFO. The source presents one byte per clock with a valid strobe. A start marker flags the first byte of each application packet. An optional end marker closes a packet whose length is not a multiple of four bytes. Each quadlet written to the FIFO carries a first-word tag, a last-word tag and a 2-bit count of the bytes it holds.

Flow control toward the source uses a ready output that the source must treat as delayed by one cycle. The block therefore drops ready while the FIFO still has room for the one byte that may already be in flight. The byte order inside each quadlet comes from a strap input that is sampled only while reset is held.

Top module: `av_quad_packer`

## Requirements
- R1: A byte is taken only at a rising edge where `src_valid` is 1. In cycles where `src_valid` is 0, the values on `src_data`, `src_sop` and `src_eop` have no effect on any quadlet written.
- R2: When the fourth byte of a quadlet is taken, the block writes that quadlet in the next cycle (`fifo_wr`=1). The write has `fifo_nbytes`=0, meaning all four bytes are valid. It has `fifo_eop`=0 unless the end marker came with that byte. It has `fifo_sop`=1 only on the first quadlet of a packet.
- R3: With `strap_le`=1 held during reset, byte k of a quadlet (k=0 is the first byte taken) lands in bits [8k+7:8k].
- R4: With `strap_le`=0 held during reset, byte k lands in bits [31-8k:24-8k]. Changes on `strap_le` after reset is released have no effect.
- R5: A byte taken with `src_eop`=1 closes the current quadlet, which is written in the next cycle with `fifo_eop`=1. Unused lanes are zero, and `fifo_nbytes` is the number of bytes held (1, 2 or 3; 0 stands for 4).
- R6: A byte taken with `src_sop`=1 while a quadlet is partly filled first closes that partial quadlet as the last word of the previous packet (`fifo_eop`=1, `fifo_nbytes`=bytes held, unused lanes zero). The new byte then starts a new packet in lane 0.
- R7: Quadlets are written one per cycle, in the order they were closed, and none is lost. When a flush from R6 and a one-byte packet close in the same cycle, the two writes appear in consecutive cycles.
- R8: `src_ready` is a registered copy of (`fifo_free` > 2). A change on `fifo_free` shows on `src_ready` one cycle later. A byte presented in the first cycle where `src_ready` is low is still taken.
- R9: While `rst_n` is 0, `fifo_wr` and `src_ready` are 0. The assembler is empty after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_le | input | 1 | Byte order strap, sampled during reset (1 = first byte in low lane) |
| src_data | input | 8 | Byte from the source |
| src_valid | input | 1 | Byte on `src_data` is valid this cycle |
| src_sop | input | 1 | First byte of an application packet |
| src_eop | input | 1 | Last byte of a packet whose length is not a multiple of 4 |
| src_ready | output | 1 | Flow control to the source, pipelined by one cycle |
| fifo_free | input | 5 | Free entries reported by the downstream FIFO |
| fifo_wr | output | 1 | Write strobe for one quadlet |
| fifo_quad | output | 32 | Quadlet data |
| fifo_sop | output | 1 | Quadlet is the first of a packet |
| fifo_eop | output | 1 | Quadlet is the last of a packet |
| fifo_nbytes | output | 2 | Valid bytes in the quadlet, 0 meaning 4 |

## Verification
Several packet shapes are streamed back to back. A four-byte packet without an end marker checks the plain full-quadlet path. A three-byte packet closed by the end marker checks zero fill and the byte count. A two-byte fragment cut off by a new start marker, followed by a five-byte packet, separates the flush path from a normal close and from a one-byte tail. A gap with junk on the data and marker lines shows that idle cycles are ignored.

The same shapes under the opposite strap value show which lane each byte lands in. Two one-byte packets that follow a mid-quadlet start marker force the pending-word path and test write ordering. A fill level stepped across the threshold, with a byte sent in the cycle where ready has just fallen, checks the one-cycle ready contract.

// File: rtl/av_pkt_pkg.sv
package av_pkt_pkg;

   typedef enum logic {
      ORDER_BE = 1'b0,
      ORDER_LE = 1'b1
   } byte_order_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/av_ready_gen.sv
module av_ready_gen #(
   parameter int unsigned FREE_W = 5,
   parameter int unsigned MARGIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREE_W-1:0] free_cnt,
   output logic              ready
);
   localparam logic [FREE_W-1:0] LIMIT = FREE_W'(MARGIN);

   logic ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= (free_cnt > LIMIT);
   end

   assign ready = ready_q;
endmodule

// File: rtl/av_lane_packer.sv
module av_lane_packer
   import av_pkt_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 4,
   localparam int unsigned QUAD_W = BYTE_W * LANES,
   localparam int unsigned NB_W   = $clog2(LANES),
   localparam int unsigned WORD_W = QUAD_W + NB_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  byte_order_e       order,
   input  logic [BYTE_W-1:0] data,
   input  logic              valid,
   input  logic              sop,
   input  logic              eop,
   output logic              flush_vld,
   output logic [WORD_W-1:0] flush_word,
   output logic              close_vld,
   output logic [WORD_W-1:0] close_word
);
   localparam logic [NB_W-1:0] LAST_LANE = NB_W'(LANES - 1);

   logic [NB_W-1:0]   cnt_q;
   logic [QUAD_W-1:0] acc_q;
   logic              head_q;

   logic              flush;
   logic [NB_W-1:0]   base_cnt;
   logic [QUAD_W-1:0] base_acc;
   logic              base_head;
   logic [NB_W-1:0]   slot;
   logic [NB_W-1:0]   cnt_inc;
   logic [QUAD_W-1:0] next_acc;
   logic              close;

   always_comb begin
      flush     = valid && sop && (cnt_q != '0);
      base_cnt  = flush ? '0 : cnt_q;
      base_acc  = flush ? '0 : acc_q;
      base_head = sop | head_q;
      slot      = (order == ORDER_LE) ? base_cnt : (LAST_LANE - base_cnt);
      cnt_inc   = base_cnt + NB_W'(1);
      close     = valid && ((base_cnt == LAST_LANE) || eop);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign next_acc[g*BYTE_W +: BYTE_W] =
         (slot == NB_W'(g)) ? data : base_acc[g*BYTE_W +: BYTE_W];
   end

   assign flush_vld  = flush;
   assign flush_word = {head_q, 1'b1, cnt_q, acc_q};
   assign close_vld  = close;
   assign close_word = {base_head, eop, cnt_inc, next_acc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         head_q <= 1'b0;
      end else if (valid) begin
         if (close) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            head_q <= 1'b0;
         end else begin
            cnt_q  <= cnt_inc;
            acc_q  <= next_acc;
            head_q <= base_head;
         end
      end
   end
endmodule

// File: rtl/av_word_stage.sv
module av_word_stage #(
   parameter int unsigned WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_vld,
   input  logic [WORD_W-1:0] a_word,
   input  logic              b_vld,
   input  logic [WORD_W-1:0] b_word,
   output logic              out_vld,
   output logic [WORD_W-1:0] out_word
);
   logic              pend_vld_q, out_vld_q;
   logic [WORD_W-1:0] pend_q, out_q;

   logic              nx_out_vld, nx_pend_vld;
   logic [WORD_W-1:0] nx_out, nx_pend;
   logic [WORD_W-1:0] first_new;

   always_comb begin
      first_new = a_vld ? a_word : b_word;
      if (pend_vld_q) begin
         nx_out_vld  = 1'b1;
         nx_out      = pend_q;
         nx_pend_vld = a_vld | b_vld;
         nx_pend     = first_new;
      end else begin
         nx_out_vld  = a_vld | b_vld;
         nx_out      = first_new;
         nx_pend_vld = a_vld & b_vld;
         nx_pend     = b_word;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld_q <= 1'b0;
         pend_q     <= '0;
         out_vld_q  <= 1'b0;
         out_q      <= '0;
      end else begin
         pend_vld_q <= nx_pend_vld;
         if (nx_pend_vld) pend_q <= nx_pend;
         out_vld_q  <= nx_out_vld;
         if (nx_out_vld) out_q <= nx_out;
      end
   end

   assign out_vld  = out_vld_q;
   assign out_word = out_q;
endmodule

// File: rtl/av_quad_packer.sv
module av_quad_packer
   import av_pkt_pkg::*;
#(
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned LANES        = 4,
   parameter int unsigned FREE_W       = 5,
   parameter int unsigned READY_MARGIN = 2,
   localparam int unsigned QUAD_W = BYTE_W * LANES,
   localparam int unsigned NB_W   = $clog2(LANES),
   localparam int unsigned WORD_W = QUAD_W + NB_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_le,
   input  logic [BYTE_W-1:0] src_data,
   input  logic              src_valid,
   input  logic              src_sop,
   input  logic              src_eop,
   output logic              src_ready,
   input  logic [FREE_W-1:0] fifo_free,
   output logic              fifo_wr,
   output logic [QUAD_W-1:0] fifo_quad,
   output logic              fifo_sop,
   output logic              fifo_eop,
   output logic [NB_W-1:0]   fifo_nbytes
);
   if (!is_pow2(LANES) || LANES < 2) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end
   if (READY_MARGIN < 2 || READY_MARGIN >= (1 << FREE_W)) begin : g_bad_margin
      $error("READY_MARGIN must cover the in-flight byte and fit FREE_W");
   end

   byte_order_e       order_q;
   logic              flush_vld, close_vld, out_vld;
   logic [WORD_W-1:0] flush_word, close_word, out_word;

   always_ff @(posedge clk) begin
      if (!rst_n) order_q <= strap_le ? ORDER_LE : ORDER_BE;
   end

   av_ready_gen #(.FREE_W(FREE_W), .MARGIN(READY_MARGIN)) ready_i (
      .clk(clk), .rst_n(rst_n), .free_cnt(fifo_free), .ready(src_ready)
   );

   av_lane_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) pack_i (
      .clk(clk), .rst_n(rst_n), .order(order_q),
      .data(src_data), .valid(src_valid), .sop(src_sop), .eop(src_eop),
      .flush_vld(flush_vld), .flush_word(flush_word),
      .close_vld(close_vld), .close_word(close_word)
   );

   av_word_stage #(.WORD_W(WORD_W)) stage_i (
      .clk(clk), .rst_n(rst_n),
      .a_vld(flush_vld), .a_word(flush_word),
      .b_vld(close_vld), .b_word(close_word),
      .out_vld(out_vld), .out_word(out_word)
   );

   assign fifo_wr     = out_vld;
   assign fifo_sop    = out_word[WORD_W-1];
   assign fifo_eop    = out_word[WORD_W-2];
   assign fifo_nbytes = out_word[QUAD_W +: NB_W];
   assign fifo_quad   = out_word[QUAD_W-1:0];
endmodule

// File: rtl/av_quad_packer_chk.sv
module av_quad_packer_chk #(
   parameter int unsigned BYTE_W       = 8,
   parameter int unsigned LANES        = 4,
   parameter int unsigned FREE_W       = 5,
   parameter int unsigned READY_MARGIN = 2,
   localparam int unsigned QUAD_W = BYTE_W * LANES,
   localparam int unsigned NB_W   = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              src_valid,
   input logic              src_eop,
   input logic              src_ready,
   input logic [FREE_W-1:0] fifo_free,
   input logic              fifo_wr,
   input logic [QUAD_W-1:0] fifo_quad,
   input logic              fifo_eop,
   input logic [NB_W-1:0]   fifo_nbytes
);
   p_reset_quiet_r9: assert property (@(posedge clk)
      !rst_n |=> (!fifo_wr && !src_ready));

   p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_free <= FREE_W'(READY_MARGIN)) |=> !src_ready);

   p_eop_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_eop) |=> fifo_wr);

   p_short_is_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && fifo_nbytes != '0) |-> fifo_eop);

   p_one_byte_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && fifo_nbytes == NB_W'(1)) |->
      (fifo_quad[QUAD_W-1:BYTE_W] == '0 || fifo_quad[QUAD_W-BYTE_W-1:0] == '0));

   p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(src_valid) && !$past(src_valid, 2)) |-> !fifo_wr);
endmodule

bind av_quad_packer av_quad_packer_chk #(
   .BYTE_W(BYTE_W), .LANES(LANES), .FREE_W(FREE_W), .READY_MARGIN(READY_MARGIN)
) chk_i (.*);

// File: tb/av_quad_packer_tb_top.sv
module av_quad_packer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_le = 1'b1;
   logic [7:0] src_data = '0;
   logic       src_valid = 1'b0, src_sop = 1'b0, src_eop = 1'b0;
   logic       src_ready;
   logic [4:0] fifo_free = 5'd16;
   logic       fifo_wr, fifo_sop, fifo_eop;
   logic [31:0] fifo_quad;
   logic [1:0] fifo_nbytes;

   int n_chk = 0, n_bad = 0, cyc = 0, ncap = 0, rd = 0;
   logic [35:0] cap_w [0:63];
   int          cap_c [0:63];
   bit          done = 0;

   // {valid, sop, eop, data}
   localparam logic [10:0] STIM [15] = '{
      11'h611, 11'h422, 11'h3FF, 11'h433, 11'h444,
      11'h655, 11'h466, 11'h577,
      11'h6A1, 11'h4A2,
      11'h6B1, 11'h4B2, 11'h4B3, 11'h4B4, 11'h5B5 };
   // {sop, eop, nbytes, quad}
   localparam logic [35:0] EXPW [5] = '{
      36'h8_4433_2211, 36'hF_0077_6655, 36'hE_0000_A2A1,
      36'h8_B4B3_B2B1, 36'h5_0000_00B5 };

   av_quad_packer dut_i (.*);

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && fifo_wr && ncap < 64) begin
         cap_w[ncap] = {fifo_sop, fifo_eop, fifo_nbytes, fifo_quad};
         cap_c[ncap] = cyc;
         ncap++;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic s, input logic e, input logic [7:0] d);
      @(negedge clk);
      src_valid = v; src_sop = s; src_eop = e; src_data = d;
   endtask

   task automatic idle(input int n);
      drive(1'b0, 1'b0, 1'b0, 8'h00);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_word(input string tag, input logic [35:0] exp);
      logic [35:0] act;
      act = (rd < ncap) ? cap_w[rd] : 36'hX_XXXX_XXXX;
      chk(rd < ncap && act === exp, tag, act, exp);
      rd++;
   endtask

   task automatic do_reset(input logic le);
      @(negedge clk);
      rst_n = 1'b0; strap_le = le;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      strap_le = ~le;
      @(negedge clk);
   endtask

   initial begin
      // R9: reset state
      strap_le = 1'b1;
      repeat (3) @(negedge clk);
      chk(fifo_wr === 1'b0, "R9 fifo_wr in reset", {35'd0, fifo_wr}, 36'd0);
      chk(src_ready === 1'b0, "R9 src_ready in reset", {35'd0, src_ready}, 36'd0);
      rst_n = 1'b1;
      strap_le = 1'b0;
      @(negedge clk);
      chk(src_ready === 1'b1, "R8 ready after reset", {35'd0, src_ready}, 36'd1);

      // Table: R1 R2 R3 R5 R6
      foreach (STIM[i]) drive(STIM[i][10], STIM[i][9], STIM[i][8], STIM[i][7:0]);
      idle(4);
      chk(ncap == 5, "R1 word count", 36'(ncap), 36'd5);
      foreach (EXPW[i]) expect_word("R2/R3/R5/R6 table word", EXPW[i]);

      // R7: flush plus back-to-back one-byte packets
      drive(1, 1, 0, 8'hC1);
      drive(1, 0, 0, 8'hC2);
      drive(1, 1, 1, 8'hD1);
      drive(1, 1, 1, 8'hE1);
      idle(4);
      expect_word("R6 flush C", 36'hE_0000_C2C1);
      expect_word("R7 pending D", 36'hD_0000_00D1);
      expect_word("R7 E", 36'hD_0000_00E1);
      chk(cap_c[rd-2] == cap_c[rd-3] + 1 && cap_c[rd-1] == cap_c[rd-2] + 1,
          "R7 consecutive writes", 36'(cap_c[rd-1] - cap_c[rd-3]), 36'd2);

      // R8: ready threshold and the absorbed byte
      fifo_free = 5'd3;
      @(negedge clk);
      chk(src_ready === 1'b1, "R8 free=3 ready", {35'd0, src_ready}, 36'd1);
      drive(1, 1, 0, 8'hF1);
      drive(1, 0, 0, 8'hF2);
      drive(1, 0, 0, 8'hF3);
      fifo_free = 5'd2;
      drive(1, 0, 0, 8'hF4);
      chk(src_ready === 1'b0, "R8 free=2 ready low", {35'd0, src_ready}, 36'd0);
      idle(3);
      chk(src_ready === 1'b0, "R8 held low", {35'd0, src_ready}, 36'd0);
      expect_word("R8 absorbed byte", 36'h8_F4F3_F2F1);
      fifo_free = 5'd16;
      @(negedge clk);
      @(negedge clk);
      chk(src_ready === 1'b1, "R8 ready back", {35'd0, src_ready}, 36'd1);

      // R4: big-endian strap, flipped after reset
      do_reset(1'b0);
      rd = ncap;
      drive(1, 1, 0, 8'h01);
      drive(1, 0, 0, 8'h02);
      drive(1, 0, 0, 8'h03);
      drive(1, 0, 0, 8'h04);
      drive(1, 1, 1, 8'h09);
      drive(1, 1, 0, 8'h0A);
      drive(1, 0, 0, 8'h0B);
      drive(1, 0, 1, 8'h0C);
      idle(4);
      expect_word("R4 BE full", 36'h8_0102_0304);
      expect_word("R4 BE one byte", 36'hD_0900_0000);
      expect_word("R4 BE three bytes", 36'hF_0A0B_0C00);

      // R9: reset clears a partial quadlet
      strap_le = 1'b1;
      drive(1, 1, 0, 8'h77);
      idle(0);
      do_reset(1'b1);
      rd = ncap;
      drive(1, 1, 1, 8'h5A);
      idle(4);
      expect_word("R9 empty after reset", 36'hD_0000_005A);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule